// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block watches sixteen input-only pins and turns each one into a level-sensitive interrupt source. Every pin passes through a two-flop synchronizer. Each channel is then compared with its own polarity bit. A per-channel debounce timer, counted in milliseconds from a shared prescaler, decides when a channel's raw status bit is set. Software reaches all state through a simple register bus: single-cycle writes, and reads that return data combinationally from the address.

A channel detects nothing until software arms it by writing its trigger bit. After it records one event, the channel disarms itself. To emulate an edge interrupt, software inverts the polarity bit and arms the channel again. Status is kept in two forms: raw, and raw gated by the enable bits. A write-one-to-clear register clears status bits, and the single interrupt output goes high whenever any enabled status bit is set.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: Register 0x00 is read-only. Its bit n gives synchronized pin n ANDed with enable bit n of 0x04. Writes to 0x00 have no effect, because the pins can never be driven.
- R3: The following registers can be written and read back: 0x04 (channel enable), 0x14 (polarity) and 0x18 (interrupt enable), each using bits 15:0 with bit n for channel n, and the per-channel timer registers at 0x40 + 4*n, each holding bits 11:0. Bits above those fields always read 0.
- R4: Detection is by level only. When polarity bit n is 1, channel n is active while its pin is high. When the bit is 0, the channel is active while its pin is low.
- R5: Writing 1 to bit n of 0x28 arms channel n, provided its enable bit is set. A channel that has never been armed never sets status. Both 0x28 and 0x24 always read 0.
- R6: An armed channel sets raw status bit n only after it has stayed active for its timer value in milliseconds, where one millisecond is TICK_CYC clock cycles. Any inactive sample restarts the count. With a timer value of 0, the bit is set on the first active synchronized sample.
- R7: A channel disarms when it sets raw status. It does not set the bit again until a new trigger write.
- R8: Raw status can be read at 0x1C. Masked status at 0x20 equals raw ANDed with 0x18. `irq` is the OR of all masked status bits.
- R9: Writing 1 to bit n of 0x24 clears raw status bit n. If a clear and a set of the same bit happen in the same cycle, the clear wins.
- R10: Clearing enable bit n disarms channel n and stops its detection. Setting the enable bit again does not re-arm the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | NCH | Asynchronous input pins |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | AW | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives a short glitch that is shorter than the debounce window. A timer that failed to restart on an inactive sample would fire on that glitch, or would fire early on the level that follows. It writes a clear in the very cycle a zero-delay channel sets its status, so a design that let the set win would leave the status bit high. It re-enables a channel after disabling it while armed, and it leaves an active pin asserted after a detection. A design that did not disarm in either case would report events that software never asked for. It also checks that each polarity fires only on its own level, and that the data register ignores writes.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NCH      = 16,
  parameter int TICK_CYC = 1000,
  parameter int DBW      = 12,
  parameter int AW       = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pins,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [AW-1:0] A_PIN   = AW'(8'h00);
  localparam logic [AW-1:0] A_EN    = AW'(8'h04);
  localparam logic [AW-1:0] A_POL   = AW'(8'h14);
  localparam logic [AW-1:0] A_IE    = AW'(8'h18);
  localparam logic [AW-1:0] A_RAW   = AW'(8'h1C);
  localparam logic [AW-1:0] A_MSK   = AW'(8'h20);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h24);
  localparam logic [AW-1:0] A_ARM   = AW'(8'h28);
  localparam int            TMR_BASE = 'h40;

  logic [NCH-1:0] s1, s2, chan_en, pol, ie, raw, armed;
  logic [NCH-1:0] active, hit, arm_p, clr_p;
  logic [DBW-1:0] tmr [NCH];
  logic [DBW-1:0] cnt [NCH];
  logic [PW-1:0]  pre;
  logic           tick;

  assign tick   = (pre == PW'(TICK_CYC - 1));
  assign active = chan_en & ~(s2 ^ pol);
  assign arm_p  = (bus_wr && bus_addr == A_ARM) ? bus_wdata[NCH-1:0] : '0;
  assign clr_p  = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NCH-1:0] : '0;
  assign irq    = |(raw & ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      pre     <= '0;
      chan_en <= '0;
      pol     <= '0;
      ie      <= '0;
      raw     <= '0;
    end else begin
      s1  <= pins;
      s2  <= s1;
      pre <= tick ? '0 : pre + 1'b1;
      raw <= (raw | hit) & ~clr_p;
      if (bus_wr && bus_addr == A_EN)  chan_en <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == A_POL) pol     <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == A_IE)  ie      <= bus_wdata[NCH-1:0];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] A_TMR = AW'(TMR_BASE + 4 * n);
    assign hit[n] = armed[n] & active[n] & (cnt[n] >= tmr[n]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed[n] <= 1'b0;
        cnt[n]   <= '0;
        tmr[n]   <= '0;
      end else begin
        if (bus_wr && bus_addr == A_TMR) tmr[n] <= bus_wdata[DBW-1:0];
        if (arm_p[n] && chan_en[n])      armed[n] <= 1'b1;
        else if (hit[n] || !chan_en[n])  armed[n] <= 1'b0;
        if (arm_p[n] || !armed[n] || !active[n]) cnt[n] <= '0;
        else if (tick && cnt[n] < tmr[n])        cnt[n] <= cnt[n] + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PIN:   bus_rdata = 32'(s2 & chan_en);
      A_EN:    bus_rdata = 32'(chan_en);
      A_POL:   bus_rdata = 32'(pol);
      A_IE:    bus_rdata = 32'(ie);
      A_RAW:   bus_rdata = 32'(raw);
      A_MSK:   bus_rdata = 32'(raw & ie);
      default: bus_rdata = '0;
    endcase
    for (int n = 0; n < NCH; n++)
      if (bus_addr == AW'(TMR_BASE + 4 * n)) bus_rdata = 32'(tmr[n]);
  end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] raw,
  input logic [NCH-1:0] armed,
  input logic [NCH-1:0] chan_en
);
  logic [NCH-1:0] arm_w, clr_w;
  assign arm_w = (bus_wr && bus_addr == AW'(8'h28)) ? bus_wdata[NCH-1:0] : '0;
  assign clr_w = (bus_wr && bus_addr == AW'(8'h24)) ? bus_wdata[NCH-1:0] : '0;

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w != '0) |=> ((raw & $past(clr_w)) == '0));
  // R5
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(armed)) == '0));
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(chan_en)) == '0));
  // R7
  disarm_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & armed & ~$past(arm_w)) == '0));
  // R5
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(8'h28) || bus_addr == AW'(8'h24)) |-> (bus_rdata == '0));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw(raw), .armed(armed),
  .chan_en(chan_en)
);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 16;
  localparam int TICK  = 4;

  logic        clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [15:0] pins = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, v;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lvl_irq_ctrl #(.NCH(NCH), .TICK_CYC(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    foreach (v[i]) ;
    for (int a = 0; a < 'h80; a += 4) begin
      rd(8'(a), v); chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", 32'(irq), 0);
  endtask

  task automatic t_regs;
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R3 polarity rw", v, 32'h0000_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF); rd(8'h5C, v); chk("R3 timer7 rw", v, 32'h0000_0FFF);
    wr(8'h7C, 32'h0001_2345); rd(8'h7C, v); chk("R3 timer15 rw", v, 32'h0000_0345);
    wr(8'h18, 32'h0000_1234); rd(8'h18, v); chk("R3 ie rw", v, 32'h0000_1234);
    wr(8'h14, 0); wr(8'h18, 0); wr(8'h7C, 0); wr(8'h5C, 0);
  endtask

  task automatic t_data;
    wr(8'h04, 32'h0000_00FF);
    pins = 16'hA5C3; cyc(4);
    rd(8'h00, v); chk("R2 data masked pins", v, 32'h0000_00C3);
    wr(8'h00, 32'hFFFF_FFFF); cyc(2);
    rd(8'h00, v); chk("R2 data write ignored", v, 32'h0000_00C3);
    rd(8'h1C, v); chk("R5 no status without trigger", v, 0);
    pins = '0; wr(8'h04, 32'h0000_FFFF); cyc(4);
  endtask

  task automatic t_polarity;
    wr(8'h14, 32'h0000_0008); cyc(1);
    wr(8'h28, 32'h0000_000C); cyc(4);
    rd(8'h1C, v); chk("R4 active-low fires, active-high waits", v, 32'h0000_0004);
    rd(8'h28, v); chk("R5 trigger reads 0", v, 0);
    pins[3] = 1; cyc(4);
    rd(8'h1C, v); chk("R4 active-high fires on high", v, 32'h0000_000C);
    wr(8'h24, 32'h0000_FFFF);
    rd(8'h1C, v); chk("R9 clear", v, 0);
    pins[3] = 0;
  endtask

  task automatic t_masked;
    wr(8'h28, 32'h0000_0004); cyc(4);
    rd(8'h20, v); chk("R8 masked with ie=0", v, 0);
    chk("R8 irq low with ie=0", 32'(irq), 0);
    wr(8'h18, 32'h0000_0004);
    rd(8'h20, v); chk("R8 masked with ie", v, 32'h0000_0004);
    chk("R8 irq high", 32'(irq), 1);
    wr(8'h24, 32'h0000_0004);
    chk("R8 irq low after clear", 32'(irq), 0);
    wr(8'h18, 0);
  endtask

  task automatic t_disarm;
    cyc(10);
    rd(8'h1C, v); chk("R7 no refire while active", v, 0);
    wr(8'h28, 32'h0000_0004); cyc(4);
    rd(8'h1C, v); chk("R7 refire after new trigger", v, 32'h0000_0004);
    wr(8'h24, 32'h0000_FFFF);
  endtask

  task automatic t_clr_prio;
    wr(8'h28, 32'h0000_0004);
    wr(8'h24, 32'h0000_0004);
    rd(8'h1C, v); chk("R9 clear wins over same-cycle set", v, 0);
    cyc(10);
    rd(8'h1C, v); chk("R7 disarmed after cleared hit", v, 0);
  endtask

  task automatic t_debounce;
    wr(8'h44, 32'd3);
    wr(8'h14, 32'h0000_0002);
    wr(8'h28, 32'h0000_0002);
    pins[1] = 1; cyc(6); pins[1] = 0; cyc(20);
    rd(8'h1C, v); chk("R6 glitch shorter than window ignored", v, 0);
    pins[1] = 1; cyc(9);
    rd(8'h1C, v); chk("R6 not set before window", v, 0);
    cyc(11);
    rd(8'h1C, v); chk("R6 set after window", v, 32'h0000_0002);
    wr(8'h24, 32'h0000_FFFF); pins[1] = 0; wr(8'h14, 0); cyc(4);
  endtask

  task automatic t_disable;
    wr(8'h04, 32'h0000_FFDF);
    wr(8'h28, 32'h0000_0020); cyc(6);
    rd(8'h1C, v); chk("R10 disabled channel silent", v, 0);
    rd(8'h00, v); chk("R10 disabled data bit 0", v & 32'h20, 0);
    wr(8'h58, 32'd5);
    wr(8'h28, 32'h0000_0040); cyc(4);
    wr(8'h04, 32'h0000_FF9F); cyc(2);
    wr(8'h04, 32'h0000_FFFF); cyc(40);
    rd(8'h1C, v); chk("R10 re-enable does not re-arm", v, 0);
    wr(8'h28, 32'h0000_0040); cyc(40);
    rd(8'h1C, v); chk("R6 long window fires once armed", v, 32'h0000_0040);
    wr(8'h24, 32'h0000_FFFF);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset;
    t_regs;
    t_data;
    t_polarity;
    t_masked;
    t_disarm;
    t_clr_prio;
    t_debounce;
    t_disable;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule